// File: doc/BRIEF.md
# LCD horizontal line timing generator

This block produces the horizontal timing of one display line for an LCD controller. A single 32-bit configuration word holds four count fields: the visible pixel count, the line clock pulse width, the wait before the line clock (front porch) and the wait before the first pixel (back porch). Every count field holds the wanted count minus one. The block runs through four phases in a fixed order: back porch, visible pixels, front porch, line clock pulse. It then starts the next line. All phases count in pixel clock ticks, and a tick is supplied on `pixTick` by a divider outside this block.

Software writes the configuration word and the mode select while `enable` is low. When `enable` rises, the block copies them into internal shadow registers, so later changes to the inputs have no effect on the running line. The outputs are:
- a line clock level,
- a gated pixel clock enable,
- a strobe that marks the visible pixel cycles,
- a one-cycle end-of-line pulse that a vertical timing block can count.

In passive mode the pixel clock enable appears only during visible pixels. In active mode it follows every tick while the block runs.

Top module: `lcd_hline_gen`

## Requirements
- R1: The visible pixel count is `timingWord[9:0]` + 1. `pixValid` is high for exactly that many pixel ticks in each line, covering 1 to 1024 pixels.
- R2: After `enable` is loaded, and after every line clock pulse ends, the back porch lasts `timingWord[31:24]` + 1 ticks before `pixValid` rises.
- R3: Each line runs its phases in this order: back porch, visible pixels, front porch, line clock pulse. It then returns to the back porch.
- R4: The front porch lasts `timingWord[23:16]` + 1 ticks, from the last `pixValid` cycle to the first `lineClk` cycle.
- R5: `lineClk` stays high for `timingWord[15:10]` + 1 ticks at the end of each line.
- R6: When `passiveMode` = 1 (passive), `pixClkEn` is high only in tick cycles where `pixValid` is high. It stays low through both porches and the line clock pulse.
- R7: When `passiveMode` = 0 (active), `pixClkEn` is high in every cycle where `pixTick` is high while the block runs.
- R8: `lineEnd` is a one-cycle pulse in the final tick cycle of the line clock pulse, once per line.
- R9: The configuration word and the mode are sampled in the first cycle where `enable` is high. Changing them while `enable` stays high has no effect on the line timing.
- R10: While `enable` is low, `lineClk`, `pixValid`, `pixClkEn` and `lineEnd` are all low. A later enable starts a fresh line at the back porch.
- R11: Phase counters advance only in cycles where `pixTick` is high. With a half-rate tick, every phase takes twice as many clock cycles.
- R12: During and right after reset, with `enable` low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; its rising edge loads the configuration |
| passiveMode | input | 1 | 1 = passive mode (gated pixel clock), 0 = active mode |
| pixTick | input | 1 | Pixel clock tick from the external divider |
| timingWord | input | 32 | Packed count fields: pixels [9:0], pulse [15:10], front [23:16], back [31:24] |
| lineClk | output | 1 | Line clock pulse |
| pixClkEn | output | 1 | Gated pixel clock enable |
| pixValid | output | 1 | High during visible pixel cycles |
| lineEnd | output | 1 | One-cycle pulse when the line clock pulse finishes |

## Verification
The bench checks that every field reads as its value plus one, using all-zero fields and all-maximum fields. A design that skipped the plus one would show each phase one tick short, and an all-zero word would then collapse to nothing. Configuration changes made while running and half-rate ticks are also tested. A design without shadow registers would stretch the visible span, and one that counted clock cycles instead of ticks would halve each phase. The bench drops `enable` in the middle of the line clock pulse and checks that the line clock falls at once and that the next enable starts a clean back porch. It also checks that passive mode holds the pixel clock enable low outside visible pixels, while active mode passes every tick.

// File: rtl/lcd_hline_pkg.sv
package lcd_hline_pkg;

  typedef enum logic [1:0] {
    PH_BACK  = 2'd0,
    PH_PIX   = 2'd1,
    PH_FRONT = 2'd2,
    PH_SYNC  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadCfg;
    logic   clrCnt;
    logic   incCnt;
    phase_e phase;
  } ctrlStrobe_t;

endpackage

// File: rtl/lcd_hline_dp.sv
module lcd_hline_dp
  import lcd_hline_pkg::*;
#(
  parameter int PPL_W = 10,
  parameter int HSW_W = 6,
  parameter int HFP_W = 8,
  parameter int HBP_W = 8,
  localparam int WORD_W = PPL_W + HSW_W + HFP_W + HBP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] timingWord,
  input  logic              passiveIn,
  input  ctrlStrobe_t       strobe,
  output logic              lastCnt,
  output logic              passiveCfg
);

  localparam int HSW_LSB = PPL_W;
  localparam int HFP_LSB = HSW_LSB + HSW_W;
  localparam int HBP_LSB = HFP_LSB + HFP_W;
  localparam int MAX_A   = (PPL_W > HSW_W) ? PPL_W : HSW_W;
  localparam int MAX_B   = (HFP_W > HBP_W) ? HFP_W : HBP_W;
  localparam int CNT_W   = (MAX_A > MAX_B) ? MAX_A : MAX_B;

  logic [PPL_W-1:0] pplQ;
  logic [HSW_W-1:0] hswQ;
  logic [HFP_W-1:0] hfpQ;
  logic [HBP_W-1:0] hbpQ;
  logic             passiveQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // shadow copy of the configuration, loaded on the enable edge (R9)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pplQ     <= '0;
      hswQ     <= '0;
      hfpQ     <= '0;
      hbpQ     <= '0;
      passiveQ <= 1'b0;
    end else if (strobe.loadCfg) begin
      pplQ     <= timingWord[PPL_W-1:0];
      hswQ     <= timingWord[HSW_LSB +: HSW_W];
      hfpQ     <= timingWord[HFP_LSB +: HFP_W];
      hbpQ     <= timingWord[HBP_LSB +: HBP_W];
      passiveQ <= passiveIn;
    end
  end

  // terminal count of the current phase, fields hold count minus one
  always_comb begin
    unique case (strobe.phase)
      PH_BACK:  limit = CNT_W'(hbpQ);
      PH_PIX:   limit = CNT_W'(pplQ);
      PH_FRONT: limit = CNT_W'(hfpQ);
      PH_SYNC:  limit = CNT_W'(hswQ);
      default:  limit = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.clrCnt) cnt <= '0;
    else if (strobe.incCnt) cnt <= cnt + 1'b1;
  end

  assign lastCnt    = (cnt == limit);
  assign passiveCfg = passiveQ;

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit); // R1

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCfg |=> ($stable(pplQ) && $stable(hswQ) && $stable(hfpQ)
                         && $stable(hbpQ) && $stable(passiveQ))); // R9

endmodule

// File: rtl/lcd_hline_ctrl.sv
module lcd_hline_ctrl
  import lcd_hline_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        pixTick,
  input  logic        lastCnt,
  input  logic        passiveCfg,
  output ctrlStrobe_t strobe,
  output logic        lineClk,
  output logic        pixClkEn,
  output logic        pixValid,
  output logic        lineEnd
);

  phase_e state;
  phase_e nextPhase;
  logic   enPrev;
  logic   run;
  logic   stepDone;

  always_ff @(posedge clk) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enable;
  end

  // counting starts the cycle after the load cycle
  assign run      = enable & enPrev;
  assign stepDone = run & pixTick & lastCnt;

  always_comb begin
    unique case (state)
      PH_BACK:  nextPhase = PH_PIX;
      PH_PIX:   nextPhase = PH_FRONT;
      PH_FRONT: nextPhase = PH_SYNC;
      PH_SYNC:  nextPhase = PH_BACK;
      default:  nextPhase = PH_BACK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         state <= PH_BACK;
    else if (!run)     state <= PH_BACK;
    else if (stepDone) state <= nextPhase;
  end

  always_comb begin
    strobe.loadCfg = enable & ~enPrev;
    strobe.clrCnt  = ~run | stepDone;
    strobe.incCnt  = run & pixTick & ~lastCnt;
    strobe.phase   = state;
  end

  assign pixValid = run & (state == PH_PIX);
  assign lineClk  = run & (state == PH_SYNC);
  assign lineEnd  = stepDone & (state == PH_SYNC);
  assign pixClkEn = run & pixTick & (~passiveCfg | (state == PH_PIX));

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> (state == phase_e'($past(state) + 2'd1))); // R3

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (run && !pixTick) |=> $stable(state)); // R11

  AST_EOL_THEN_BACK: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (!lineClk && !lineEnd)); // R8

  AST_PASSIVE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (passiveCfg && !pixValid) |-> !pixClkEn); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(lineClk || pixValid || pixClkEn || lineEnd)); // R10

endmodule

// File: rtl/lcd_hline_gen.sv
module lcd_hline_gen
  import lcd_hline_pkg::*;
#(
  parameter int PPL_W = 10,
  parameter int HSW_W = 6,
  parameter int HFP_W = 8,
  parameter int HBP_W = 8,
  localparam int WORD_W = PPL_W + HSW_W + HFP_W + HBP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              passiveMode,
  input  logic              pixTick,
  input  logic [WORD_W-1:0] timingWord,
  output logic              lineClk,
  output logic              pixClkEn,
  output logic              pixValid,
  output logic              lineEnd
);

  ctrlStrobe_t strobe;
  logic        lastCnt;
  logic        passiveCfg;

  lcd_hline_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .pixTick    (pixTick),
    .lastCnt    (lastCnt),
    .passiveCfg (passiveCfg),
    .strobe     (strobe),
    .lineClk    (lineClk),
    .pixClkEn   (pixClkEn),
    .pixValid   (pixValid),
    .lineEnd    (lineEnd)
  );

  lcd_hline_dp #(
    .PPL_W (PPL_W),
    .HSW_W (HSW_W),
    .HFP_W (HFP_W),
    .HBP_W (HBP_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .timingWord (timingWord),
    .passiveIn  (passiveMode),
    .strobe     (strobe),
    .lastCnt    (lastCnt),
    .passiveCfg (passiveCfg)
  );

endmodule

// File: tb/lcd_hline_gen_tb.sv
`timescale 1ns/100ps
module lcd_hline_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        passiveMode = 1'b0;
  logic        pixTick = 1'b1;
  logic        tickHalf = 1'b0;
  logic [31:0] timingWord = '0;
  logic        lineClk, pixClkEn, pixValid, lineEnd;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) pixTick <= tickHalf ? ~pixTick : 1'b1;

  lcd_hline_gen u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .passiveMode(passiveMode),
    .pixTick(pixTick), .timingWord(timingWord), .lineClk(lineClk),
    .pixClkEn(pixClkEn), .pixValid(pixValid), .lineEnd(lineEnd)
  );

  // {passive, back[7:0], front[7:0], pulse[5:0], pixels[9:0]}
  localparam logic [32:0] VECS [6] = '{
    {1'b1, 8'd0,   8'd0,   6'd0,  10'd0},
    {1'b0, 8'd3,   8'd2,   6'd1,  10'd7},
    {1'b1, 8'd10,  8'd5,   6'd4,  10'd15},
    {1'b0, 8'd255, 8'd255, 6'd63, 10'd1023},
    {1'b1, 8'd1,   8'd20,  6'd2,  10'd99},
    {1'b0, 8'd7,   8'd0,   6'd9,  10'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sampleStep();
    @(negedge clk);
    #1;
  endtask

  task automatic runLine(input logic [31:0] word, input logic [31:0] altWord,
                         input bit passive, output int validOut);
    int pplN = int'(word[9:0]) + 1;
    int hsN  = int'(word[15:10]) + 1;
    int fpN  = int'(word[23:16]) + 1;
    int bpN  = int'(word[31:24]) + 1;
    int len  = pplN + hsN + fpN + bpN;
    int validCnt = 0, syncCnt = 0, enCnt = 0, eolCnt = 0;
    int firstV = -1, lastV = -1, firstS = -1, eolIdx = -1;
    bit earlyV = 1'b0, onV = 1'b0;
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    timingWord  = word;
    passiveMode = passive;
    enable      = 1'b1;
    @(negedge clk);
    timingWord  = altWord;
    passiveMode = ~passive;
    #1;
    for (int i = 0; i <= len + bpN; i++) begin
      if (i > 0) sampleStep();
      if (i < len) begin
        if (pixValid) begin
          validCnt++;
          if (firstV < 0) firstV = i;
          lastV = i;
        end
        if (lineClk) begin
          syncCnt++;
          if (firstS < 0) firstS = i;
        end
        if (pixClkEn) enCnt++;
        if (lineEnd) begin
          eolCnt++;
          eolIdx = i;
        end
      end
      if (i == len + bpN - 1) earlyV = pixValid;
      if (i == len + bpN)     onV = pixValid;
    end
    check(validCnt == pplN, "R1 visible count", validCnt, pplN);
    check(firstV == bpN, "R2 back porch first line", firstV, bpN);
    check(!earlyV && onV, "R2 back porch next line", int'(onV), 1);
    check(firstV < lastV + 1 && lastV < firstS, "R3 phase order", firstS, lastV + 1);
    check(firstS - lastV - 1 == fpN, "R4 front porch", firstS - lastV - 1, fpN);
    check(syncCnt == hsN, "R5 pulse width", syncCnt, hsN);
    check(eolCnt == 1 && eolIdx == len - 1, "R8 end-of-line pulse", eolIdx, len - 1);
    if (passive) check(enCnt == pplN, "R6 passive gating", enCnt, pplN);
    else         check(enCnt == len, "R7 active gating", enCnt, len);
    validOut = validCnt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got;
    // R12: reset state
    repeat (3) sampleStep();
    check(!(lineClk || pixValid || pixClkEn || lineEnd), "R12 outputs in reset",
          int'({lineClk, pixValid, pixClkEn, lineEnd}), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) sampleStep();
    check(!(lineClk || pixValid || pixClkEn || lineEnd), "R12 outputs after reset",
          int'({lineClk, pixValid, pixClkEn, lineEnd}), 0);

    // table walk
    foreach (VECS[k]) runLine(VECS[k][31:0], VECS[k][31:0], VECS[k][32], got);

    // R9: reprogramming while enabled is ignored
    runLine({8'd2, 8'd1, 6'd1, 10'd4}, {8'd9, 8'd9, 6'd9, 10'd40}, 1'b1, got);
    check(got == 5, "R9 shadowed config", got, 5);

    // R10: drop enable inside the line clock pulse
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    timingWord  = {8'd3, 8'd2, 6'd20, 10'd3};
    passiveMode = 1'b0;
    enable      = 1'b1;
    for (int i = 0; i < 100 && !lineClk; i++) sampleStep();
    sampleStep();
    check(lineClk == 1'b1, "R10 pulse reached", int'(lineClk), 1);
    @(negedge clk);
    enable = 1'b0;
    #1;
    check(!(lineClk || pixValid || pixClkEn || lineEnd), "R10 quiet on disable",
          int'({lineClk, pixValid, pixClkEn, lineEnd}), 0);
    sampleStep();
    check(!(lineClk || pixValid || pixClkEn || lineEnd), "R10 quiet while low",
          int'({lineClk, pixValid, pixClkEn, lineEnd}), 0);
    runLine({8'd3, 8'd2, 6'd20, 10'd3}, {8'd3, 8'd2, 6'd20, 10'd3}, 1'b0, got);
    check(got == 4, "R10 restart clean", got, 4);

    // R11: half-rate tick
    begin
      int enCnt = 0, clkCnt = 0, eolCnt = 0;
      @(negedge clk);
      enable   = 1'b0;
      tickHalf = 1'b1;
      repeat (2) @(negedge clk);
      timingWord  = {8'd2, 8'd1, 6'd1, 10'd5};
      passiveMode = 1'b1;
      enable      = 1'b1;
      for (int i = 0; i < 200 && eolCnt == 0; i++) begin
        sampleStep();
        if (pixClkEn) enCnt++;
        if (lineClk)  clkCnt++;
        if (lineEnd)  eolCnt++;
      end
      check(enCnt == 6, "R11 ticks in visible span", enCnt, 6);
      check(clkCnt == 4, "R11 pulse stretched by tick rate", clkCnt, 4);
      check(eolCnt == 1, "R8 end-of-line with slow tick", eolCnt, 1);
      @(negedge clk);
      enable   = 1'b0;
      tickHalf = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule